// File: doc/BRIEF.md
# Charge Safety Timer with Thermal Slowdown

This block watches how long a linear battery charger has spent in its current charging phase. It aborts the charge if either phase lasts too long. A base tick from an external time source drives one shared elapsed counter. The counter is compared against one of two limits: a short one while the cell is being conditioned at low voltage, and a long one during bulk fast charge. When the selected limit is reached, a latched fault output tells the charge controller to stop supplying current.

Three inputs shape how time is counted:

- A slow-mode input is asserted while the charger is limiting current for thermal or input-source reasons. It makes only every second tick count, so the allowed time doubles.
- A pause input freezes the count while the input supply is absent or over-voltage. Counting later resumes from the held value.
- Timer-disable mode is used when no battery pack is fitted. It holds the counter and fault at zero.

Several events clear both the count and the fault:

- an explicit restart pulse, which covers lockout, charger disable, output short and refresh;
- any change of phase;
- entering or leaving timer-disable mode.

Both limits are parameters. A real design might use roughly 1800 and 36000 one-second ticks, and a bench can use a handful.

Top module: `chg_safety_timer`

## Requirements
- R1: After a synchronous reset, `elapsed_o` is 0 and `fault_o` is 0.
- R2: With slow mode, pause, disable mode and restart all low, each cycle with `tick_i` high raises `elapsed_o` by one. The new value is visible after the clock edge that samples the tick. A cycle without a tick leaves the count unchanged.
- R3: While `slow_i` is high, only every second unpaused tick advances the count. The first such tick after slow mode is entered, or after a clear, does not advance it.
- R4: While `pause_i` is high, ticks are ignored and the count holds its value. This includes the slow-mode alternation. Counting resumes from the held value once pause drops.
- R5: In precharge (`fast_phase_i` = 0), the tick that brings `elapsed_o` to `PRE_LIMIT` also sets `fault_o` on the same edge.
- R6: In fast charge (`fast_phase_i` = 1), the count passes `PRE_LIMIT` without a fault. The tick that brings it to `FAST_LIMIT` sets `fault_o`.
- R7: Once set, `fault_o` stays high and `elapsed_o` stops advancing until a clearing event occurs.
- R8: A cycle with `restart_i` high clears `elapsed_o` and `fault_o` on the next edge. Restart takes priority over a tick in the same cycle.
- R9: A change of `fast_phase_i` in either direction clears `elapsed_o` and `fault_o` on the edge that samples the new phase.
- R10: While `ttdm_i` is high, `elapsed_o` is held at 0 and `fault_o` is low. The cycle that samples `ttdm_i` falling also clears, so counting restarts from 0 after leaving the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse from the base time source |
| fast_phase_i | input | 1 | Phase: 0 precharge, 1 fast charge |
| slow_i | input | 1 | Half-rate request (thermal or input-current limiting) |
| pause_i | input | 1 | Freeze request (sleep or input over-voltage) |
| ttdm_i | input | 1 | Timer-disable mode (no pack fitted) |
| restart_i | input | 1 | Clear pulse (lockout, disable, short, refresh) |
| elapsed_o | output | CNT_W | Registered elapsed tick count |
| fault_o | output | 1 | Registered, latched timeout fault |

## Verification
The embedded properties watch four things on every cycle:

- the count never moves by more than one step;
- it is frozen under pause;
- the fault stays latched and only rises with the count exactly at the selected limit;
- every clear or disable-mode cycle leaves count and fault at zero.

The half-rate alternation under slow mode, the choice between the two limits, and restarts caused by phase or mode edges need the bench's directed sequences. Those sequences compare the exact count after each cycle against an expected queue.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;
  typedef enum logic {
    PH_PRE  = 1'b0,
    PH_FAST = 1'b1
  } phase_e;
endpackage

// File: rtl/chg_tmr_rate.sv
// Turns raw ticks into count-advance strobes, honouring pause and half rate.
module chg_tmr_rate (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic slow_i,
  input  logic pause_i,
  input  logic clr_i,
  output logic adv_o
);
  logic half_q;

  // half_q marks that one slow tick has been swallowed and the next counts
  always_ff @(posedge clk) begin
    if (rst || clr_i || !slow_i) begin
      half_q <= 1'b0;
    end else if (tick_i && !pause_i) begin
      half_q <= ~half_q;
    end
  end

  assign adv_o = tick_i & ~pause_i & (~slow_i | half_q);
endmodule

// File: rtl/chg_tmr_restart.sv
// Collects every event that must restart the timer, including phase and mode edges.
module chg_tmr_restart
  import chg_tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_i,
  input  logic   ttdm_i,
  input  logic   restart_i,
  output logic   clr_o
);
  phase_e phase_q;
  logic   ttdm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PRE;
      ttdm_q  <= 1'b0;
    end else begin
      phase_q <= phase_i;
      ttdm_q  <= ttdm_i;
    end
  end

  // ttdm_q covers the cycle that leaves disable mode
  assign clr_o = restart_i | ttdm_i | ttdm_q | (phase_i != phase_q);
endmodule

// File: rtl/chg_tmr_core.sv
// Shared elapsed counter with a phase-selected limit and latched fault.
module chg_tmr_core
  import chg_tmr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_LIMIT  = 1800,
  parameter int FAST_LIMIT = 36000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             clr_i,
  input  phase_e           phase_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] PRE_LIM  = CNT_W'(PRE_LIMIT);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, lim;
  logic             fault_q;

  generate
    if (PRE_LIMIT == FAST_LIMIT) begin : g_one_lim
      assign lim = PRE_LIM;
    end else begin : g_two_lim
      assign lim = (phase_i == PH_FAST) ? FAST_LIM : PRE_LIM;
    end
  endgenerate

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (adv_i && !fault_q) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == lim) fault_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = fault_q;

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R7
  fault_latch_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q && !clr_i |=> fault_q && $stable(cnt_q));
  // R5
  fault_at_lim_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> cnt_q == $past(lim));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0 && !fault_q);
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
  import chg_tmr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_LIMIT  = 1800,
  parameter int FAST_LIMIT = 36000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             fast_phase_i,
  input  logic             slow_i,
  input  logic             pause_i,
  input  logic             ttdm_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             fault_o
);
  phase_e phase;
  logic   clr, adv;

  assign phase = fast_phase_i ? PH_FAST : PH_PRE;

  chg_tmr_restart u_restart (
    .clk(clk), .rst(rst), .phase_i(phase), .ttdm_i(ttdm_i),
    .restart_i(restart_i), .clr_o(clr)
  );

  chg_tmr_rate u_rate (
    .clk(clk), .rst(rst), .tick_i(tick_i), .slow_i(slow_i),
    .pause_i(pause_i), .clr_i(clr), .adv_o(adv)
  );

  chg_tmr_core #(
    .CNT_W(CNT_W), .PRE_LIMIT(PRE_LIMIT), .FAST_LIMIT(FAST_LIMIT)
  ) u_core (
    .clk(clk), .rst(rst), .adv_i(adv), .clr_i(clr), .phase_i(phase),
    .cnt_o(elapsed_o), .fault_o(fault_o)
  );

  // R4
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pause_i && !clr |=> $stable(elapsed_o));
  // R10
  ttdm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ttdm_i |=> elapsed_o == '0 && !fault_o);
endmodule

// File: tb/chg_safety_timer_tb.sv
module chg_safety_timer_tb;
  localparam int CW = 8, PRE = 5, FAST = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b0, fast = 1'b0, slow = 1'b0, pause = 1'b0, ttdm = 1'b0, restart = 1'b0;
  logic [CW-1:0] elapsed;
  logic          fault;

  always #4 clk = ~clk;  // 125 MHz

  chg_safety_timer #(.CNT_W(CW), .PRE_LIMIT(PRE), .FAST_LIMIT(FAST)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .fast_phase_i(fast), .slow_i(slow),
    .pause_i(pause), .ttdm_i(ttdm), .restart_i(restart),
    .elapsed_o(elapsed), .fault_o(fault)
  );

  typedef struct {
    logic [CW-1:0] el;
    logic          f;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  // driver: inputs for one cycle plus the expected outputs after that edge
  task automatic step(input logic t, input logic ph, input logic sl, input logic pa,
                      input logic td, input logic rs, input int el, input logic f,
                      input string tag);
    exp_t it;
    @(negedge clk);
    tick = t; fast = ph; slow = sl; pause = pa; ttdm = td; restart = rs;
    it.el = CW'(el); it.f = f; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: samples a quarter period after each rising edge
  always @(posedge clk) begin
    exp_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (elapsed !== it.el || fault !== it.f) begin
        errors++;
        $display("FAIL %s: elapsed=%0d fault=%0b expected elapsed=%0d fault=%0b",
                 it.tag, elapsed, fault, it.el, it.f);
      end
    end
  end

  initial begin
    step(0,0,0,0,0,0, 0,0, "R1");           // under reset
    @(negedge clk); rst = 1'b0;
    step(0,0,0,0,0,0, 0,0, "R1");
    step(1,0,0,0,0,0, 1,0, "R2");
    step(1,0,0,0,0,0, 2,0, "R2");
    step(0,0,0,0,0,0, 2,0, "R2");
    step(1,0,0,1,0,0, 2,0, "R4");
    step(1,0,0,1,0,0, 2,0, "R4");
    step(0,0,0,1,0,0, 2,0, "R4");
    step(1,0,0,0,0,0, 3,0, "R4");
    step(1,0,0,0,0,0, 4,0, "R5");
    step(1,0,0,0,0,0, 5,1, "R5");
    step(1,0,0,0,0,0, 5,1, "R7");
    step(1,0,0,1,0,0, 5,1, "R7");
    step(0,0,0,0,0,1, 0,0, "R8");
    step(1,0,1,0,0,0, 0,0, "R3");
    step(1,0,1,0,0,0, 1,0, "R3");
    step(0,0,1,0,0,0, 1,0, "R3");
    step(1,0,1,0,0,0, 1,0, "R3");
    step(1,0,1,0,0,0, 2,0, "R3");
    step(1,0,1,1,0,0, 2,0, "R4");           // paused slow tick leaves alternation alone
    step(1,0,1,0,0,0, 2,0, "R3");
    step(1,0,1,0,0,0, 3,0, "R3");
    step(1,0,0,0,0,0, 4,0, "R2");
    step(0,1,0,0,0,0, 0,0, "R9");           // into fast charge
    for (int i = 1; i < FAST; i++) step(1,1,0,0,0,0, i,0, "R6");
    step(1,1,0,0,0,0, FAST,1, "R6");
    step(1,1,0,0,0,0, FAST,1, "R7");
    step(0,0,0,0,0,0, 0,0, "R9");           // back to precharge
    step(1,0,0,0,0,0, 1,0, "R2");
    step(1,0,0,0,0,0, 2,0, "R2");
    step(1,0,0,0,0,1, 0,0, "R8");           // restart beats tick
    step(1,0,0,0,0,0, 1,0, "R2");
    step(1,0,0,0,1,0, 0,0, "R10");
    step(1,0,0,0,1,0, 0,0, "R10");
    step(1,0,0,0,0,0, 0,0, "R10");          // leaving mode clears
    step(1,0,0,0,0,0, 1,0, "R10");
    step(0,0,0,0,0,0, 1,0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule